// File: doc/BRIEF.md
# Inter-Access Idle Cycle Inserter

This block sits in an external bus controller between the access sequencer and the bus pins. It paces the sequencer's stream of external access requests. Each new request is compared with the access that went before it: its direction, its chip-select space, and whether either access is a DMA single transfer with its data driven by an external device. That comparison selects a 2-bit idle-cycle code. The block then holds back the grant for that many cycles, so a slow device that is still turning off its data driver cannot collide with the next transfer.

Requests use a valid/ready handshake. The sequencer raises `req_valid` with the access attributes. It must hold `req_valid` and every attribute steady until `req_ready` is high, and an access is accepted on the clock edge where both are high. Back-pressure has two sources: the idle cycles still owed, and an access that has been accepted but is not yet complete. The sequencer reports completion with a one-cycle `acc_done` pulse. Idle settings are read live from the configuration inputs. The per-space settings are taken from the space of the previous access. The DMA settings replace them when the DMA rule applies.

Top module: `idle_gap_inserter`

## Requirements
- R1: An access is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is never high while `req_valid` is low. While `req_valid` is high and `req_ready` is low, the requester holds `req_valid`, `req_write`, `req_space` and `req_dma_ext` stable. After reset `req_ready` is low.
- R2: After an access is accepted, `req_ready` stays low until `acc_done` has been sampled high. `acc_done` is high only while an accepted access is still in progress.
- R3: The first request after reset is granted in the cycle it is presented, with no idle cycles.
- R4: An idle code maps 0→0, 1→1, 2→2 and 3→4 cycles. A request presented when no access is in progress, or still waiting when `acc_done` ends the current access, sees `req_ready` low for exactly that many cycles and high in the next cycle. A stall never lasts more than 4 cycles.
- R5: When the previous access was a write, the code is bits [1:0] of the previous space's 10-bit field. This holds for any direction and any space of the next access.
- R6: When the previous access was a read and the next is a write, the code is bits [3:2] if both target the same space, and bits [5:4] otherwise.
- R7: When the previous access was a read and the next is a read, the code is bits [7:6] if both target the same space, and bits [9:8] otherwise.
- R8: When the previous access had `req_dma_ext` set and `cfg_dma_any` is 1, the code is `cfg_dma_gap` for any next access.
- R9: When the previous access had `req_dma_ext` set and `cfg_dma_any` is 0, the code is `cfg_dma_gap` only if the next access also has `req_dma_ext` set. Otherwise R5 to R7 apply.
- R10: Space n's field occupies bits [10n+9:10n] of `cfg_space_gap`. R5 to R7 always read the previous access's space, never the next one's.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_space_gap | input | NSPACE*10 | Per-space idle codes, 10 bits per space |
| cfg_dma_gap | input | 2 | Idle code after a DMA single transfer with externally driven data |
| cfg_dma_any | input | 1 | 1: DMA code applies before any next access; 0: only before another such DMA access |
| req_valid | input | 1 | Sequencer presents an access |
| req_ready | output | 1 | Grant; access accepted when valid and ready are high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_space | input | $clog2(NSPACE) | Chip-select space of the access |
| req_dma_ext | input | 1 | Access is a DMA single transfer with data driven by an external device |
| acc_done | input | 1 | One-cycle pulse at completion of the accepted access |

## Verification
Several properties are checked on every cycle. They cover the handshake rules, the absence of a grant while an access is in progress, and `acc_done` arriving only during an access. They also cover an immediate grant before any access has taken place, and the upper bound of four stalled cycles. The exact number of stall cycles is only shown by the bench's scenarios. That number depends on the pair classification, the same-space versus different-space choice, the DMA mode bit and the field taken from the previous space. The bench compares the measured stall of every access against a model of the requirements, using both directed pairs and random ones.

// File: rtl/idle_gap_pkg.sv
package idle_gap_pkg;

  // width of one idle code and of one space's set of codes
  localparam int unsigned CODE_W  = 2;
  localparam int unsigned NCAT    = 5;
  localparam int unsigned FIELD_W = CODE_W * NCAT;

  // longest stall a code can request, and widths derived from it
  localparam int unsigned GAP_MAX  = 4;
  localparam int unsigned NEED_W   = $clog2(GAP_MAX) + 1;
  localparam int unsigned CNT_W    = $clog2(GAP_MAX);

  typedef logic [CODE_W-1:0]  gap_code_t;
  typedef logic [FIELD_W-1:0] space_field_t;
  typedef logic [NEED_W-1:0]  gap_need_t;

  // position of each category inside a space field
  typedef enum logic [2:0] {
    CAT_AFTER_WRITE = 3'd0,
    CAT_RW_SAME     = 3'd1,
    CAT_RW_DIFF     = 3'd2,
    CAT_RR_SAME     = 3'd3,
    CAT_RR_DIFF     = 3'd4
  } pair_cat_e;

  typedef enum logic [1:0] {
    PACE_OPEN = 2'd0,
    PACE_WAIT = 2'd1,
    PACE_BUSY = 2'd2
  } pace_state_e;

  function automatic gap_need_t code_to_cycles(gap_code_t c);
    case (c)
      2'd0:    return gap_need_t'(0);
      2'd1:    return gap_need_t'(1);
      2'd2:    return gap_need_t'(2);
      default: return gap_need_t'(GAP_MAX);
    endcase
  endfunction

endpackage

// File: rtl/gap_field_mux.sv
module gap_field_mux
  import idle_gap_pkg::*;
#(
  parameter int unsigned NSPACE = 6,
  localparam int unsigned SPW = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
  input  logic [NSPACE*FIELD_W-1:0] cfg_flat,
  input  logic [SPW-1:0]            sel_space,
  output space_field_t              field
);

  space_field_t per_space [NSPACE];

  for (genvar s = 0; s < NSPACE; s++) begin : g_split
    assign per_space[s] = cfg_flat[s*FIELD_W +: FIELD_W];
  end

  always_comb begin
    field = '0;
    for (int s = 0; s < NSPACE; s++) begin
      if (sel_space == SPW'(s)) field = per_space[s];
    end
  end

endmodule

// File: rtl/gap_classify.sv
module gap_classify
  import idle_gap_pkg::*;
#(
  parameter int unsigned NSPACE = 6,
  localparam int unsigned SPW = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
  input  logic                      prev_valid,
  input  logic                      prev_write,
  input  logic [SPW-1:0]            prev_space,
  input  logic                      prev_dma_ext,
  input  logic                      nxt_write,
  input  logic [SPW-1:0]            nxt_space,
  input  logic                      nxt_dma_ext,
  input  logic [NSPACE*FIELD_W-1:0] cfg_space_gap,
  input  gap_code_t                 cfg_dma_gap,
  input  logic                      cfg_dma_any,
  output gap_need_t                 need
);

  space_field_t prev_field;
  pair_cat_e    cat;
  gap_code_t    pair_code;
  gap_code_t    final_code;
  logic         same_space;
  logic         dma_rule;

  gap_field_mux #(.NSPACE(NSPACE)) u_mux (
    .cfg_flat  (cfg_space_gap),
    .sel_space (prev_space),
    .field     (prev_field)
  );

  assign same_space = (prev_space == nxt_space);
  assign dma_rule   = prev_dma_ext && (cfg_dma_any || nxt_dma_ext);

  always_comb begin
    if (prev_write)      cat = CAT_AFTER_WRITE;
    else if (nxt_write)  cat = same_space ? CAT_RW_SAME : CAT_RW_DIFF;
    else                 cat = same_space ? CAT_RR_SAME : CAT_RR_DIFF;
  end

  always_comb begin
    pair_code = '0;
    for (int c = 0; c < int'(NCAT); c++) begin
      if (cat == pair_cat_e'(c)) pair_code = prev_field[c*CODE_W +: CODE_W];
    end
  end

  assign final_code = dma_rule ? cfg_dma_gap : pair_code;
  assign need       = prev_valid ? code_to_cycles(final_code) : '0;

endmodule

// File: rtl/gap_pacer.sv
module gap_pacer
  import idle_gap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      req_valid,
  input  gap_need_t need,
  input  logic      acc_done,
  output logic      req_ready
);

  pace_state_e           state;
  logic [CNT_W-1:0]      cnt;

  always_comb begin
    case (state)
      PACE_OPEN: req_ready = req_valid && (need == '0);
      PACE_WAIT: req_ready = req_valid && (cnt == '0);
      default:   req_ready = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PACE_OPEN;
      cnt   <= '0;
    end else begin
      case (state)
        PACE_OPEN: begin
          if (req_valid) begin
            if (need == '0) begin
              state <= PACE_BUSY;
            end else begin
              cnt   <= CNT_W'(need - gap_need_t'(1));
              state <= PACE_WAIT;
            end
          end
        end
        PACE_WAIT: begin
          if (cnt != '0)       cnt   <= cnt - 1'b1;
          else if (req_valid)  state <= PACE_BUSY;
        end
        default: begin
          if (acc_done) state <= PACE_OPEN;
        end
      endcase
    end
  end

endmodule

// File: rtl/idle_gap_inserter.sv
module idle_gap_inserter
  import idle_gap_pkg::*;
#(
  parameter int unsigned NSPACE = 6,
  localparam int unsigned SPW = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSPACE*FIELD_W-1:0] cfg_space_gap,
  input  logic [CODE_W-1:0]         cfg_dma_gap,
  input  logic                      cfg_dma_any,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic                      req_write,
  input  logic [SPW-1:0]            req_space,
  input  logic                      req_dma_ext,
  input  logic                      acc_done
);

  logic           prev_valid;
  logic           prev_write;
  logic [SPW-1:0] prev_space;
  logic           prev_dma_ext;
  gap_need_t      need;
  logic           accept;

  assign accept = req_valid && req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid   <= 1'b0;
      prev_write   <= 1'b0;
      prev_space   <= '0;
      prev_dma_ext <= 1'b0;
    end else if (accept) begin
      prev_valid   <= 1'b1;
      prev_write   <= req_write;
      prev_space   <= req_space;
      prev_dma_ext <= req_dma_ext;
    end
  end

  gap_classify #(.NSPACE(NSPACE)) u_classify (
    .prev_valid    (prev_valid),
    .prev_write    (prev_write),
    .prev_space    (prev_space),
    .prev_dma_ext  (prev_dma_ext),
    .nxt_write     (req_write),
    .nxt_space     (req_space),
    .nxt_dma_ext   (req_dma_ext),
    .cfg_space_gap (cfg_space_gap),
    .cfg_dma_gap   (cfg_dma_gap),
    .cfg_dma_any   (cfg_dma_any),
    .need          (need)
  );

  gap_pacer u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .need      (need),
    .acc_done  (acc_done),
    .req_ready (req_ready)
  );

endmodule

// File: rtl/idle_gap_inserter_chk.sv
module idle_gap_inserter_chk
  import idle_gap_pkg::*;
#(
  parameter int unsigned NSPACE = 6,
  localparam int unsigned SPW = (NSPACE > 1) ? $clog2(NSPACE) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           req_ready,
  input logic           req_write,
  input logic [SPW-1:0] req_space,
  input logic           req_dma_ext,
  input logic           acc_done
);

  logic       seen;
  logic       busy;
  logic [3:0] stall_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen      <= 1'b0;
      busy      <= 1'b0;
      stall_cnt <= '0;
    end else begin
      if (req_valid && req_ready) begin
        seen <= 1'b1;
        busy <= 1'b1;
      end else if (acc_done) begin
        busy <= 1'b0;
      end
      if (req_valid && !req_ready && !busy) begin
        if (stall_cnt != 4'hF) stall_cnt <= stall_cnt + 4'd1;
      end else begin
        stall_cnt <= '0;
      end
    end
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write)
                               && $stable(req_space) && $stable(req_dma_ext));

  p_ready_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  p_no_grant_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_done_in_access_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |-> busy);

  p_first_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !seen && req_valid |-> req_ready);

  p_stall_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stall_cnt <= 4'(GAP_MAX));

endmodule

bind idle_gap_inserter idle_gap_inserter_chk #(.NSPACE(NSPACE)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_write   (req_write),
  .req_space   (req_space),
  .req_dma_ext (req_dma_ext),
  .acc_done    (acc_done)
);

// File: tb/idle_gap_inserter_bench.sv
module idle_gap_inserter_bench;

  localparam int NS  = 6;
  localparam int SPW = $clog2(NS);
  localparam int FW  = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NS*FW-1:0]  cfg_space_gap = '0;
  logic [1:0]        cfg_dma_gap = '0;
  logic              cfg_dma_any = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [SPW-1:0]    req_space = '0;
  logic              req_dma_ext = 1'b0;
  logic              acc_done = 1'b0;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model of the previous accepted access
  bit       m_has_prev = 0;
  bit       m_wr = 0;
  int       m_space = 0;
  bit       m_dma = 0;

  always #4 clk = ~clk;

  idle_gap_inserter #(.NSPACE(NS)) u_idle_gap_inserter (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_space_gap (cfg_space_gap),
    .cfg_dma_gap   (cfg_dma_gap),
    .cfg_dma_any   (cfg_dma_any),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_write     (req_write),
    .req_space     (req_space),
    .req_dma_ext   (req_dma_ext),
    .acc_done      (acc_done)
  );

  function automatic int dec(logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 1;
      2'd2: return 2;
      default: return 4;
    endcase
  endfunction

  function automatic logic [1:0] field_code(int sp, int pos);
    return cfg_space_gap[sp*FW + pos*2 +: 2];
  endfunction

  function automatic int exp_gap(bit nwr, int nsp, bit ndma);
    if (!m_has_prev) return 0;
    if (m_dma && (cfg_dma_any || ndma)) return dec(cfg_dma_gap);
    if (m_wr) return dec(field_code(m_space, 0));
    if (nwr) return dec(field_code(m_space, (nsp == m_space) ? 1 : 2));
    return dec(field_code(m_space, (nsp == m_space) ? 3 : 4));
  endfunction

  function automatic string exp_tag(bit nwr, int nsp, bit ndma);
    if (!m_has_prev) return "R3";
    if (m_dma && cfg_dma_any) return "R8";
    if (m_dma) return "R9";
    if (m_wr) return (nsp != m_space) ? "R10" : "R5";
    if (nwr) return "R6";
    return "R7";
  endfunction

  task automatic check(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, expv, $time);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // request already presented at a negedge with the pacer open: count stalls
  task automatic measure(bit nwr, int nsp, bit ndma);
    int expv;
    int stall;
    string tag;
    expv  = exp_gap(nwr, nsp, ndma);
    tag   = exp_tag(nwr, nsp, ndma);
    stall = 0;
    #1;
    while (!req_ready && stall < 12) begin
      @(negedge clk);
      #1;
      stall++;
    end
    check(stall == expv, {tag, " R4 stall cycles"}, stall, expv);
    @(posedge clk);
    m_has_prev = 1;
    m_wr = nwr;
    m_space = nsp;
    m_dma = ndma;
  endtask

  // after an accept: present next request, hold done off, then complete
  task automatic busy_then_done(bit nwr, int nsp, bit ndma, int hold, bit present);
    @(negedge clk);
    req_valid   = present;
    req_write   = nwr;
    req_space   = SPW'(nsp);
    req_dma_ext = ndma;
    for (int k = 0; k < hold; k++) begin
      #1;
      check(req_ready == 1'b0, "R2 ready during access", int'(req_ready), 0);
      @(negedge clk);
    end
    acc_done = 1'b1;
    #1;
    check(req_ready == 1'b0, "R2 ready on done cycle", int'(req_ready), 0);
    @(negedge clk);
    acc_done = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    bit dw[12];
    int ds[12];
    bit dd[12];
    bit nwr;
    int nsp;
    bit ndma;
    // directed pairs
    dw = '{0,1,0,0,0,1,0,1,0,0,1,0};
    ds = '{0,0,1,1,0,1,2,2,3,3,0,4};
    dd = '{0,0,0,0,0,0,1,0,1,1,0,0};
    // space fields: {rr_diff, rr_same, rw_diff, rw_same, after_write}
    for (int s = 0; s < NS; s++) cfg_space_gap[s*FW +: FW] = 10'b11_01_11_01_11;
    cfg_space_gap[0*FW +: FW] = 10'b10_01_11_10_01;
    cfg_space_gap[1*FW +: FW] = 10'b01_11_00_10_11;
    cfg_space_gap[2*FW +: FW] = 10'b00_10_01_11_10;
    cfg_space_gap[3*FW +: FW] = 10'b11_00_10_01_00;
    cfg_dma_gap = 2'd3;
    cfg_dma_any = 1'b0;

    repeat (3) @(negedge clk);
    #1;
    check(req_ready == 1'b0, "R1 ready low in reset", int'(req_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(req_ready == 1'b0, "R1 ready low without valid", int'(req_ready), 0);

    @(negedge clk);
    req_valid = 1'b1;
    req_write = dw[0];
    req_space = SPW'(ds[0]);
    req_dma_ext = dd[0];
    measure(dw[0], ds[0], dd[0]);

    for (int i = 1; i < 12; i++) begin
      busy_then_done(dw[i], ds[i], dd[i], 1 + (i % 3), 1'b1);
      if (i == 10) cfg_dma_any = 1'b1;
      measure(dw[i], ds[i], dd[i]);
    end

    // a zero code gives an immediate grant
    cfg_dma_gap = 2'd0;
    busy_then_done(1'b0, 1, 1'b0, 1, 1'b1);
    measure(1'b0, 1, 1'b0);

    // random phase with a fixed seed
    void'($urandom(32'h5eed_1d1e));
    for (int i = 0; i < 300; i++) begin
      nwr  = 1'($urandom_range(0, 1));
      nsp  = $urandom_range(0, NS - 1);
      ndma = ($urandom_range(0, 3) == 0);
      busy_then_done(nwr, nsp, ndma, $urandom_range(1, 3), 1'b1);
      if ($urandom_range(0, 3) == 0) begin
        for (int s = 0; s < NS; s++) cfg_space_gap[s*FW +: FW] = 10'($urandom);
        cfg_dma_gap = 2'($urandom);
        cfg_dma_any = 1'($urandom);
      end
      measure(nwr, nsp, ndma);
    end

    busy_then_done(1'b0, 0, 1'b0, 1, 1'b0);
    #1;
    check(req_ready == 1'b0, "R1 idle ready low", int'(req_ready), 0);
    finish_run();
  end

endmodule